// File: doc/BRIEF.md
# Streaming 2x2 Stride-2 Max Pooling Stage

This stage takes a feature map streamed in raster order and produces its 2x2, stride-2 max-pooled version as a stream. Each pixel carries `LANES * NUM_GRP` channels. They arrive as `NUM_GRP` consecutive beats, each beat holding `LANES` signed values. The stage never holds a full input row. For every output column and channel group it keeps one slot holding a running maximum, so its storage is `IMG_W/2 * NUM_GRP` beats, which is half an input row.

The top-left pixel of a window overwrites its slot. Each of the other three pixels reads the slot, takes the lane-wise signed maximum with the incoming beat, and writes the result back. The bottom-right pixel completes the window. Its result is pushed into a small output FIFO, which lets a slower consumer apply back-pressure. Both edges use valid/ready handshakes. The input is held off only when the FIFO could not absorb a result that is in flight.

Frame height is not configured. The stage tracks only row parity, so maps with an even number of rows can follow each other with no gap.

Top module: `pool2x2_stage`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Lane l of the output beat for group g of output pixel (X,Y) equals the largest input value in lane l of group g over input pixels (2X,2Y), (2X+1,2Y), (2X,2Y+1) and (2X+1,2Y+1). Lane l occupies bits `[l*DATA_W +: DATA_W]`.
- R3: Output beats come in raster order of output pixels, with groups in ascending order within each pixel. Each output pixel produces exactly `NUM_GRP` beats, and the stage emits no other beats.
- R4: Values are compared as two's-complement signed numbers. Windows made only of negative values yield their least negative value.
- R5: Frames of even height may follow each other back to back with no idle cycle between them, and each frame is pooled correctly.
- R6: No input beat is lost under back-pressure. While `out_ready` is held low long enough, `in_ready` falls to 0 and the stage accepts no further input.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged on the next cycle.
- R8: With `NUM_GRP` = 1, the beats of an even and the following odd column use the same slot in back-to-back cycles, and the result is still the correct maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Stage accepts the input beat |
| in_data | input | LANES*DATA_W | One channel group of one input pixel |
| out_valid | output | 1 | Pooled beat present |
| out_ready | input | 1 | Consumer accepts the pooled beat |
| out_data | output | LANES*DATA_W | One channel group of one pooled pixel |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is the write-back of one beat's maximum and the read of the next beat from the same slot. This happens on every even/odd column pair when there is a single group. The bench provokes it with a second instance that has `NUM_GRP` = 1, fed with gap-free input, and judges every pooled value against a window maximum computed in software.

The second pair is a FIFO push from a completed window and a pop by the consumer in the same cycle. Random `out_ready` patterns and a long stall followed by release provoke this collision. Each output beat is judged for order and value, the held value under stall is judged, and the count of beats at the end shows that nothing was dropped or duplicated.

// File: rtl/pool2x2_pkg.sv
package pool2x2_pkg;
  // Role of an input beat within its 2x2 window
  typedef enum logic [1:0] {
    POS_SEED  = 2'd0,  // even row, even column: overwrite slot
    POS_FOLD  = 2'd1,  // intermediate pixel: read-compare-write
    POS_FINAL = 2'd2   // odd row, odd column: window complete
  } win_pos_t;
endpackage

// File: rtl/pool_raster_ctr.sv
module pool_raster_ctr
  import pool2x2_pkg::*;
#(
  parameter int IMG_W   = 8,
  parameter int NUM_GRP = 2,
  parameter int AW      = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [AW-1:0] slot,
  output win_pos_t      pos
);
  localparam int XW = (IMG_W > 2) ? $clog2(IMG_W) : 1;
  localparam int GB = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;

  logic [XW-1:0] col;
  logic [GB-1:0] grp;
  logic          row_odd;

  wire grp_wrap = (grp == GB'(NUM_GRP - 1));
  wire col_wrap = (col == XW'(IMG_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      col     <= '0;
      grp     <= '0;
      row_odd <= 1'b0;
    end else if (step) begin
      if (grp_wrap) begin
        grp <= '0;
        if (col_wrap) begin
          col     <= '0;
          row_odd <= ~row_odd;
        end else begin
          col <= col + 1'b1;
        end
      end else begin
        grp <= grp + 1'b1;
      end
    end
  end

  always_comb begin
    slot = AW'((32'(col) >> 1) * NUM_GRP + 32'(grp));
    if (!row_odd && !col[0])
      pos = POS_SEED;
    else if (row_odd && col[0])
      pos = POS_FINAL;
    else
      pos = POS_FOLD;
  end
endmodule

// File: rtl/pool_halfline_ram.sv
module pool_halfline_ram #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // simple dual-port, registered read, read-before-write on collision
  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
    if (re)
      rdata <= mem[raddr];
  end
endmodule

// File: rtl/pool_lane_max.sv
module pool_lane_max #(
  parameter int LANES  = 2,
  parameter int DATA_W = 8
) (
  input  logic [LANES*DATA_W-1:0] a,
  input  logic [LANES*DATA_W-1:0] b,
  output logic [LANES*DATA_W-1:0] y
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    wire signed [DATA_W-1:0] va = a[l*DATA_W +: DATA_W];
    wire signed [DATA_W-1:0] vb = b[l*DATA_W +: DATA_W];
    assign y[l*DATA_W +: DATA_W] = (va > vb) ? va : vb;
  end
endmodule

// File: rtl/pool_out_fifo.sv
module pool_out_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 16,
  parameter int CW    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             valid,
  output logic [CW-1:0]    count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push)
      mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign dout  = mem[rd_ptr];
  assign valid = (count != '0);
endmodule

// File: rtl/pool2x2_stage.sv
module pool2x2_stage
  import pool2x2_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int LANES      = 2,
  parameter int NUM_GRP    = 2,
  parameter int IMG_W      = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*DATA_W-1:0] in_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES*DATA_W-1:0] out_data
);
  localparam int BW    = LANES * DATA_W;
  localparam int SLOTS = (IMG_W / 2) * NUM_GRP;
  localparam int AW    = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int CW    = $clog2(FIFO_DEPTH + 1);

  logic          accept;
  logic [AW-1:0] cur_slot;
  win_pos_t      cur_pos;

  // stage-1 registers: beat whose slot read is in flight
  logic          s1_valid;
  win_pos_t      s1_pos;
  logic [AW-1:0] s1_slot;
  logic [BW-1:0] s1_data;
  logic          byp_hit;
  logic [BW-1:0] byp_data;

  logic [BW-1:0] ram_q, s1_old, s1_max, s1_result;
  logic          s1_push;
  logic [CW-1:0] fifo_cnt;
  logic [CW:0]   room_need;

  assign accept = in_valid && in_ready;

  pool_raster_ctr #(.IMG_W(IMG_W), .NUM_GRP(NUM_GRP), .AW(AW)) u_ctr (
    .clk  (clk),
    .rst  (rst),
    .step (accept),
    .slot (cur_slot),
    .pos  (cur_pos)
  );

  pool_halfline_ram #(.DEPTH(SLOTS), .WIDTH(BW), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (s1_valid),
    .waddr (s1_slot),
    .wdata (s1_result),
    .re    (accept),
    .raddr (cur_slot),
    .rdata (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst)
      s1_valid <= 1'b0;
    else
      s1_valid <= accept;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      s1_pos   <= cur_pos;
      s1_slot  <= cur_slot;
      s1_data  <= in_data;
      // slot being written this edge is the one being read: forward it
      byp_hit  <= s1_valid && (s1_slot == cur_slot);
      byp_data <= s1_result;
    end
  end

  assign s1_old = byp_hit ? byp_data : ram_q;

  pool_lane_max #(.LANES(LANES), .DATA_W(DATA_W)) u_max (
    .a (s1_data),
    .b (s1_old),
    .y (s1_max)
  );

  assign s1_result = (s1_pos == POS_SEED) ? s1_data : s1_max;
  assign s1_push   = s1_valid && (s1_pos == POS_FINAL);

  pool_out_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BW), .CW(CW)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (s1_push),
    .din   (s1_result),
    .pop   (out_valid && out_ready),
    .dout  (out_data),
    .valid (out_valid),
    .count (fifo_cnt)
  );

  // reserve room for a result still in stage 1
  assign room_need = {1'b0, fifo_cnt} + {{CW{1'b0}}, s1_push};
  assign in_ready  = (room_need < (CW+1)'(FIFO_DEPTH));
endmodule

// File: rtl/pool2x2_stage_chk.sv
module pool2x2_stage_chk #(
  parameter int BEAT_W     = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int CW         = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [BEAT_W-1:0] out_data,
  input logic [CW-1:0]     fifo_cnt,
  input logic              s1_push
);
  localparam logic [CW-1:0] FULL_C = CW'(FIFO_DEPTH);

  // R6: occupancy never passes capacity
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    fifo_cnt <= FULL_C);

  // R6: a completed window always finds room
  a_r6_push_has_room: assert property (@(posedge clk) disable iff (rst)
    s1_push |-> (fifo_cnt < FULL_C) || (out_valid && out_ready));

  // R6: with nothing buffered or in flight, input is accepted
  a_r6_ready_when_idle: assert property (@(posedge clk) disable iff (rst)
    (fifo_cnt == '0 && !s1_push) |-> in_ready);

  // R7: a stalled output beat is held
  a_r7_hold_data: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind pool2x2_stage pool2x2_stage_chk #(
  .BEAT_W(LANES*DATA_W), .FIFO_DEPTH(FIFO_DEPTH), .CW($clog2(FIFO_DEPTH+1))
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .fifo_cnt  (fifo_cnt),
  .s1_push   (s1_push)
);

// File: tb/pool2x2_stage_bench.sv
module pool_harness #(
  parameter int LANES = 2,
  parameter int NGRP  = 2
) (
  input  logic clk,
  input  logic rst,
  output int   checks,
  output int   fails,
  output logic done
);
  localparam int DW  = 8;
  localparam int IW  = 8;
  localparam int GW  = LANES * DW;
  localparam int NCH = LANES * NGRP;

  logic          in_valid, in_ready, out_valid, out_ready;
  logic [GW-1:0] in_data, out_data;

  pool2x2_stage #(.DATA_W(DW), .LANES(LANES), .NUM_GRP(NGRP), .IMG_W(IW),
                  .FIFO_DEPTH(4)) u_pool2x2_stage (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  logic signed [DW-1:0] img [6][IW][NCH];
  logic [GW-1:0] expq [$];
  int    seq_chk = 0, seq_fail = 0, mon_chk = 0, mon_fail = 0;
  int    n_out = 0, n_exp = 0, rmode = 0, gapmode = 0;
  string tag = "R2";
  logic  pv = 0, pr = 0;
  logic [GW-1:0] pd = '0;

  assign checks = seq_chk + mon_chk;
  assign fails  = seq_fail + mon_fail;

  // consumer
  initial begin
    out_ready = 1'b0;
    forever begin
      @(posedge clk); #1;
      case (rmode)
        0: out_ready = 1'b1;
        1: out_ready = ($urandom_range(0, 1) == 1);
        default: out_ready = 1'b0;
      endcase
    end
  end

  // monitor: compare every transferred beat; check holding under stall
  always @(negedge clk) begin
    if (!rst) begin
      if (pv && !pr) begin
        mon_chk++;
        if (!(out_valid && out_data == pd)) begin
          mon_fail++;
          $display("FAIL R7 held beat changed: valid=%0b data=%h expected data=%h",
                   out_valid, out_data, pd);
        end
      end
      if (out_valid && out_ready) begin
        mon_chk++;
        n_out++;
        if (expq.size() == 0) begin
          mon_fail++;
          $display("FAIL R3 extra beat %h, expected none", out_data);
        end else begin
          logic [GW-1:0] e;
          e = expq.pop_front();
          if (out_data !== e) begin
            mon_fail++;
            $display("FAIL %s beat %0d: got %h expected %h", tag, n_out, out_data, e);
          end
        end
      end
      pv = out_valid; pr = out_ready; pd = out_data;
    end
  end

  task automatic send_beat(input logic [GW-1:0] d, input int gap);
    in_data  = d;
    in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
    repeat (gap) begin @(posedge clk); #1; end
  endtask

  function automatic logic signed [DW-1:0] pick(input int mode);
    case (mode)
      1: return DW'($urandom_range(128, 255));   // negative only
      2: case ($urandom_range(0, 3))
           0: return -8'sd128;
           1: return 8'sd127;
           2: return -8'sd1;
           default: return 8'sd0;
         endcase
      default: return DW'($urandom_range(0, 255));
    endcase
  endfunction

  task automatic run_frame(input int h, input int mode);
    for (int y = 0; y < h; y++)
      for (int x = 0; x < IW; x++)
        for (int c = 0; c < NCH; c++)
          img[y][x][c] = pick(mode);
    for (int yy = 0; yy < h / 2; yy++)
      for (int xx = 0; xx < IW / 2; xx++)
        for (int g = 0; g < NGRP; g++) begin
          logic [GW-1:0] e;
          for (int l = 0; l < LANES; l++) begin
            int m;
            m = img[2*yy][2*xx][g*LANES+l];
            for (int k = 1; k < 4; k++) begin
              int v;
              v = img[2*yy + k/2][2*xx + k%2][g*LANES+l];
              if (v > m) m = v;
            end
            e[l*DW +: DW] = m[DW-1:0];
          end
          expq.push_back(e);
          n_exp++;
        end
    for (int y = 0; y < h; y++)
      for (int x = 0; x < IW; x++)
        for (int g = 0; g < NGRP; g++) begin
          logic [GW-1:0] d;
          for (int l = 0; l < LANES; l++)
            d[l*DW +: DW] = img[y][x][g*LANES+l];
          send_beat(d, gapmode ? $urandom_range(0, 2) : 0);
        end
  endtask

  initial begin
    done     = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    @(negedge clk);
    while (rst) @(negedge clk);
    // R1 reset state
    seq_chk++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      seq_fail++;
      $display("FAIL R1 after reset: out_valid=%b in_ready=%b expected 0 1",
               out_valid, in_ready);
    end
    @(posedge clk); #1;
    // R2/R8: random values, free-running consumer, no input gaps
    tag = "R2/R8"; rmode = 0; gapmode = 0;
    run_frame(2, 0);
    // R4: all-negative windows
    tag = "R4"; gapmode = 1;
    run_frame(4, 1);
    // R5: back-to-back frames, extreme values, random consumer
    tag = "R5"; rmode = 1; gapmode = 0;
    run_frame(4, 2);
    run_frame(2, 2);
    // R6: consumer stalled while input streams
    tag = "R6"; rmode = 2;
    fork
      run_frame(6, 0);
      begin
        repeat (150) @(posedge clk);
        @(negedge clk);
        seq_chk++;
        if (in_ready !== 1'b0 || out_valid !== 1'b1) begin
          seq_fail++;
          $display("FAIL R6 under stall: in_ready=%b out_valid=%b expected 0 1",
                   in_ready, out_valid);
        end
        @(posedge clk); #1;
        rmode = 1;
      end
    join
    while (expq.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
    // R3: nothing extra, nothing missing
    seq_chk++;
    if (out_valid !== 1'b0 || n_out != n_exp) begin
      seq_fail++;
      $display("FAIL R3 beat count: got %0d (out_valid=%b) expected %0d (out_valid=0)",
               n_out, out_valid, n_exp);
    end
    seq_chk++;
    if (in_ready !== 1'b1) begin
      seq_fail++;
      $display("FAIL R6 idle in_ready=%b expected 1", in_ready);
    end
    done = 1'b1;
  end
endmodule

module pool2x2_stage_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  int   chk_a, fail_a, chk_b, fail_b;
  logic done_a, done_b;
  logic ended = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  pool_harness #(.LANES(2), .NGRP(2)) u_grp2 (
    .clk(clk), .rst(rst), .checks(chk_a), .fails(fail_a), .done(done_a));

  pool_harness #(.LANES(4), .NGRP(1)) u_grp1 (
    .clk(clk), .rst(rst), .checks(chk_b), .fails(fail_b), .done(done_b));

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
  end

  initial begin
    wait (done_a && done_b);
    if (!ended) begin
      ended = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", chk_a + chk_b, fail_a + fail_b);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      $display("FAIL watchdog expired: done=%b%b expected 11", done_a, done_b);
      $display("  TB_RESULT checks=%0d failures=%0d", chk_a + chk_b + 1, fail_a + fail_b + 1);
      $finish;
    end
  end
endmodule